// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of an asynchronous-control DRAM refreshed inside its retention window. A free-running interval timer fires once per retention period divided by the number of rows, converted to clock cycles. Each firing adds one to a count of owed refreshes. The scheduler requests the memory bus from the access controller while anything is owed. When the controller grants the bus, the scheduler runs one refresh cycle on the strobe pins.

Two refresh styles can be chosen per cycle. In counter-driven style, the column strobe falls first and the device picks the row itself. In row-addressed style, the scheduler drives its own row counter onto the address bus and pulses only the row strobe. The owed count absorbs short deferrals, such as a long page burst that holds the bus. When the count reaches its ceiling, an urgent flag tells the controller to close its page.

The standard organisations are 4096 rows in 64 ms and 2048 rows in 32 ms, or 4096 rows in 128 ms for the low-power variant. Each is obtained by setting the row width and the retention time. Pulse width and precharge are counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: The interval is INTERVAL = RETENTION_MS*1000*CLK_MHZ / 2**ROW_BITS clock cycles (integer division). The owed count rises by one on every INTERVAL-th rising edge after reset release, unless it is at its ceiling or a refresh completes on the same edge.
- R2: The owed count never exceeds MAX_DEBT. A timer event at the ceiling is dropped. `urgent` is high exactly when the owed count equals MAX_DEBT.
- R3: `ref_req` is high whenever the owed count is nonzero or a refresh cycle is in progress, and low otherwise.
- R4: A refresh cycle starts only on a rising edge where `ref_req` and `grant` are both high. At any other time, `grant` has no effect on the strobes or the address enable.
- R5: With `mode_sel`=0 (counter-driven style), `cas_n` goes low one cycle before `ras_n` falls and stays low while `ras_n` is low. `addr_oe` stays 0 throughout.
- R6: With `mode_sel`=1 (row-addressed style), `cas_n` stays high. `addr_oe` is 1 for the cycle before `ras_n` falls and for as long as `ras_n` is low, while `row_addr` holds the row being refreshed.
- R7: Each refresh holds `ras_n` low for exactly TRAS_CYC cycles. It is followed by TRP_CYC cycles with `ras_n` high before the cycle completes. Two row-strobe pulses are therefore separated by at least TRP_CYC+1 high cycles.
- R8: Completion of a refresh lowers the owed count by one on the edge that ends precharge. If a timer event and a completion fall on the same edge, the count is unchanged.
- R9: `row_addr` advances by one after each completed row-addressed refresh and wraps from 2**ROW_BITS-1 to 0. Counter-driven refreshes leave it unchanged.
- R10: `mode_sel` is sampled on the edge that starts a cycle. Changing it during the cycle does not alter that cycle's pin sequence.
- R11: During reset, `ras_n`=1, `cas_n`=1, `addr_oe`=0, `ref_req`=0, `urgent`=0, `owed`=0 and `row_addr`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Refresh style for the next cycle: 0 counter-driven, 1 row-addressed |
| grant | input | 1 | Bus granted by the access controller |
| ref_req | output | 1 | Refresh wanted or in progress |
| urgent | output | 1 | Owed count at its ceiling; page must be closed |
| owed | output | $clog2(MAX_DEBT+1) | Number of refreshes owed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Scheduler drives the address bus |
| row_addr | output | ROW_BITS | Row presented in row-addressed style |

## Verification
The bench first holds `grant` low for well over MAX_DEBT intervals. This separates plain counting from saturation, and shows whether `urgent` tracks the ceiling. A random phase then drives grant runs of random length with `mode_sel` toggled every cycle. Long denials pile up debt and short ones let it drain. Mid-cycle mode flips show whether the style is latched at the start and whether tick/completion collisions are netted correctly. A final directed run of back-to-back row-addressed refreshes carries the row counter through its wrap to zero, and a closing counter-driven stretch confirms the row stays put.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_SETUP = 2'd1,
        RS_ACT   = 2'd2,
        RS_PRE   = 2'd3
    } rs_state_e;

    typedef enum logic {
        RM_COUNTER = 1'b0,
        RM_ROWADDR = 1'b1
    } rs_mode_e;

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
    parameter int INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST_V = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        tick  = (cur_q.cnt == LAST_V);
        if (tick) nxt_d.cnt = '0;
        else      nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
    parameter int MAX_DEBT = 8,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          done,
    output logic [DW-1:0] owed,
    output logic          urgent,
    output logic          pending
);
    localparam logic [DW-1:0] MAX_V = DW'(MAX_DEBT);

    typedef struct packed {
        logic [DW-1:0] owed;
    } debt_t;

    debt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case ({tick, done})
            2'b10: if (cur_q.owed != MAX_V) nxt_d.owed = cur_q.owed + 1'b1;
            2'b01: if (cur_q.owed != '0)    nxt_d.owed = cur_q.owed - 1'b1;
            default: nxt_d = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign owed    = cur_q.owed;
    assign urgent  = (cur_q.owed == MAX_V);
    assign pending = (cur_q.owed != '0);

    // R2
    debt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= MAX_V);

    // R1
    debt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !done && owed < MAX_V) |=> owed == $past(owed) + 1'b1);

    // R8
    debt_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && done) |=> $stable(owed));

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import refresh_pkg::*;
#(
    parameter int ROW_BITS = 12,
    parameter int TRAS_CYC = 10,
    parameter int TRP_CYC  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pending,
    input  logic                grant,
    input  logic                mode_sel,
    output logic                ras_n,
    output logic                cas_n,
    output logic                addr_oe,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                active,
    output logic                done
);
    localparam int MAXC = (TRAS_CYC > TRP_CYC) ? TRAS_CYC : TRP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(TRAS_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(TRP_CYC - 1);

    typedef struct packed {
        rs_state_e           state;
        rs_mode_e            mode;
        logic [CW-1:0]       cnt;
        logic [ROW_BITS-1:0] row;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        done  = 1'b0;
        unique case (cur_q.state)
            RS_IDLE: begin
                if (pending && grant) begin
                    nxt_d.state = RS_SETUP;
                    nxt_d.mode  = mode_sel ? RM_ROWADDR : RM_COUNTER;
                end
            end
            RS_SETUP: begin
                nxt_d.state = RS_ACT;
                nxt_d.cnt   = '0;
            end
            RS_ACT: begin
                if (cur_q.cnt == RAS_LAST) begin
                    nxt_d.state = RS_PRE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            RS_PRE: begin
                if (cur_q.cnt == PRE_LAST) begin
                    nxt_d.state = RS_IDLE;
                    nxt_d.cnt   = '0;
                    done        = 1'b1;
                    if (cur_q.mode == RM_ROWADDR) nxt_d.row = cur_q.row + 1'b1;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: nxt_d.state = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= RS_IDLE;
            cur_q.mode  <= RM_COUNTER;
            cur_q.cnt   <= '0;
            cur_q.row   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    logic strobing;
    assign strobing = (cur_q.state == RS_SETUP) || (cur_q.state == RS_ACT);

    assign ras_n    = (cur_q.state != RS_ACT);
    assign cas_n    = !(strobing && cur_q.mode == RM_COUNTER);
    assign addr_oe  = strobing && (cur_q.mode == RM_ROWADDR);
    assign row_addr = cur_q.row;
    assign active   = (cur_q.state != RS_IDLE);

    // R4
    start_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(grant) && $past(pending));

    // R6
    ro_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (cas_n != !addr_oe) || (!cas_n && !addr_oe));

    // R7
    ras_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ras_n && $past(ras_n));

    // R9
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_q.mode == RM_ROWADDR) |=> row_addr == $past(row_addr) + 1'b1);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(cur_q.mode));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int ROW_BITS     = 12,
    parameter int RETENTION_MS = 64,
    parameter int CLK_MHZ      = 200,
    parameter int MAX_DEBT     = 8,
    parameter int TRAS_CYC     = 10,
    parameter int TRP_CYC      = 7,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_sel,
    input  logic                grant,
    output logic                ref_req,
    output logic                urgent,
    output logic [DW-1:0]       owed,
    output logic                ras_n,
    output logic                cas_n,
    output logic                addr_oe,
    output logic [ROW_BITS-1:0] row_addr
);
    localparam int ROWS     = 2 ** ROW_BITS;
    localparam int INTERVAL = (RETENTION_MS * 1000 * CLK_MHZ) / ROWS;

    logic tick, done, pending, active;

    refresh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    refresh_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .done    (done),
        .owed    (owed),
        .urgent  (urgent),
        .pending (pending)
    );

    refresh_seq #(
        .ROW_BITS (ROW_BITS),
        .TRAS_CYC (TRAS_CYC),
        .TRP_CYC  (TRP_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pending),
        .grant    (grant),
        .mode_sel (mode_sel),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .addr_oe  (addr_oe),
        .row_addr (row_addr),
        .active   (active),
        .done     (done)
    );

    assign ref_req = pending || active;

    // R3
    urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> ref_req);

    // R5
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !addr_oe) |-> $past(!cas_n));

endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
    // Clock rate parameter scaled down so a full row wrap fits a short run
    localparam int ROW_BITS = 11;
    localparam int RET_MS   = 32;
    localparam int CLK_MHZ  = 1;
    localparam int MAXD     = 8;
    localparam int TRAS     = 3;
    localparam int TRP      = 2;
    localparam int INTERVAL = (RET_MS * 1000 * CLK_MHZ) / (2 ** ROW_BITS);
    localparam int NROWS    = 2 ** ROW_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0;
    logic grant = 1'b0;
    logic ref_req, urgent, ras_n, cas_n, addr_oe;
    logic [3:0] owed;
    logic [ROW_BITS-1:0] row_addr;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .ROW_BITS(ROW_BITS), .RETENTION_MS(RET_MS), .CLK_MHZ(CLK_MHZ),
        .MAX_DEBT(MAXD), .TRAS_CYC(TRAS), .TRP_CYC(TRP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .grant(grant),
        .ref_req(ref_req), .urgent(urgent), .owed(owed), .ras_n(ras_n),
        .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr)
    );

    int n_chk = 0, n_fail = 0;
    int edge_n = 0;
    always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

    // bench model state
    int  exp_owed = 0, exp_row = 0;
    bit  in_cycle = 0, cur_ro = 0, pend_done = 0, prev_req = 0, wrapped = 0;
    int  lo_run = 0, hi_run = 1000, pre_cnt = 0;
    bit  g_nxt = 0, m_nxt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_owed(int o, bit t, bit d);
        if (t && !d) return (o < MAXD) ? o + 1 : o;
        if (d && !t) return (o > 0) ? o - 1 : o;
        return o;
    endfunction

    task automatic step();
        bit tick_now, done_now, g_edge, m_edge;
        @(negedge clk);
        g_edge   = grant;
        m_edge   = mode_sel;
        tick_now = (edge_n > 0) && (edge_n % INTERVAL == 0);
        done_now = pend_done;
        pend_done = 0;
        exp_owed = next_owed(exp_owed, tick_now, done_now);
        if (done_now) begin
            in_cycle = 0;
            pre_cnt  = 0;
            if (cur_ro) begin
                exp_row = (exp_row + 1) % NROWS;
                if (exp_row == 0) begin
                    wrapped = 1;
                    chk(row_addr == 0, "R9 row wrap to zero", int'(row_addr), 0);
                end
            end
        end
        // pin monitor
        if (!in_cycle) begin
            if (!ras_n) chk(0, "R4 row strobe without start", 0, 1);
            else if (!cas_n || addr_oe) begin
                in_cycle = 1;
                cur_ro   = addr_oe;
                lo_run   = 0;
                chk(g_edge && prev_req, "R4 start needs grant and request", int'(g_edge), 1);
                chk(cur_ro == m_edge, "R10 style sampled at start", int'(cur_ro), int'(m_edge));
                chk(cas_n == addr_oe, "R5 R6 setup pins", int'(cas_n), int'(addr_oe));
            end
        end else begin
            if (!ras_n) begin
                if (lo_run == 0)
                    chk(hi_run >= TRP + 1, "R7 precharge gap", hi_run, TRP + 1);
                lo_run++;
                if (cur_ro) chk(cas_n && addr_oe, "R6 row-addressed pins", {cas_n, addr_oe}, 3);
                else        chk(!cas_n && !addr_oe, "R5 counter-driven pins", {cas_n, addr_oe}, 0);
            end else if (lo_run > 0) begin
                if (pre_cnt == 0) chk(lo_run == TRAS, "R7 row strobe width", lo_run, TRAS);
                pre_cnt++;
                chk(cas_n && !addr_oe, "R5 R6 precharge pins", {cas_n, addr_oe}, 2);
                if (pre_cnt == TRP) pend_done = 1;
            end else begin
                chk(cas_n == cur_ro && addr_oe == cur_ro, "R10 setup pins held", {cas_n, addr_oe}, {cur_ro, cur_ro});
            end
        end
        if (!ras_n) hi_run = 0; else hi_run++;
        chk(int'(owed) == exp_owed, "R1 R8 owed count", int'(owed), exp_owed);
        chk(urgent == (exp_owed == MAXD), "R2 urgent flag", int'(urgent), int'(exp_owed == MAXD));
        chk(int'(row_addr) == exp_row, "R9 row counter", int'(row_addr), exp_row);
        if (exp_owed != 0 || in_cycle)
            chk(ref_req == 1'b1, "R3 request high", int'(ref_req), 1);
        else
            chk(ref_req == 1'b0, "R3 request low", int'(ref_req), 0);
        prev_req = ref_req;
        grant    = g_nxt;
        mode_sel = m_nxt;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", edge_n, 0);
        finish_run();
    end

    initial begin
        int run_left;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ras_n && cas_n, "R11 strobes idle in reset", {ras_n, cas_n}, 3);
        chk(!addr_oe, "R11 address enable off", int'(addr_oe), 0);
        chk(!ref_req && !urgent, "R11 no request", {ref_req, urgent}, 0);
        chk(owed == 0 && row_addr == 0, "R11 counters cleared", int'(owed), 0);
        rst_n = 1'b1;

        // R2 long denial: debt climbs and saturates
        g_nxt = 0; m_nxt = 0;
        repeat (10 * INTERVAL + 3) step();
        chk(owed == 4'(MAXD) && urgent, "R2 saturated after denial", int'(owed), MAXD);

        // random grant runs, mode flipping every cycle
        run_left = 0;
        for (int i = 0; i < 6000; i++) begin
            if (run_left == 0) begin
                run_left = int'($urandom % 60) + 1;
                g_nxt    = $urandom % 2;
            end
            run_left--;
            m_nxt = $urandom % 2;
            step();
        end

        // R9 directed wrap with back-to-back row-addressed refreshes
        g_nxt = 1; m_nxt = 1;
        for (int i = 0; i < 40000 && !wrapped; i++) step();
        repeat (40) step();
        chk(wrapped, "R9 wrap reached", int'(wrapped), 1);

        // R9 counter-driven refreshes leave the row alone
        m_nxt = 0;
        repeat (100) step();
        g_nxt = 0;
        repeat (5) step();
        finish_run();
    end
endmodule